// File: doc/BRIEF.md
# PCI Base Address Register with Address Decode

This block holds a single base address register of a PCI function, together with the comparator that claims bus cycles falling inside the window that register describes. Parameters fix the kind of window (I/O, memory below 4 GB, or memory anywhere in a 64-bit space), whether a memory window is marked prefetchable, and the window size as a power of two. Configuration software programs the base through a byte-enabled configuration write port and reads it back through a configuration read port. The read value carries the hardwired type bits and zeros in every bit below the window size, so writing all ones and reading back reveals the size.

A 64-bit window spans two configuration dwords, selected by a single select input. The low dword holds the type bits and the lower address bits, and the upper dword holds address bits 63:32. The block also keeps the two space enables of the function's command register. A bus address presented together with its space type raises `hit` only when the address falls inside the programmed window, the space type matches the window kind, and that space is enabled. Clearing or setting an enable therefore unmaps or maps the window on the next clock edge.

Top module: `pci_bar_decode`

## Requirements
- R1: After reset the programmed base is zero in both dwords, both space enables read 0 and `hit` is low.
- R2: An I/O window reads bit 0 of the low dword as 1 and bit 1 as 0, whatever was written.
- R3: A memory window reads bit 0 of the low dword as 0, bits 2:1 as 2'b00 for a below-4-GB window or 2'b10 for a 64-bit window (2'b01 and 2'b11 never appear), and bit 3 as the prefetchable parameter.
- R4: Every low-dword bit below log2 of the window size reads as its type bit or 0. Writing all ones to the low dword reads back the inverted size-minus-one mask with the type bits ORed in.
- R5: A configuration write changes only the byte lanes whose enable bit is set (bit n of `cfg_be` covers data bits 8n+7:8n).
- R6: With `cfg_sel_hi` set, a 64-bit window accesses address bits 63:32, writable from bit log2(size) upward. For any other window kind that dword reads 0 and writes to it are ignored.
- R7: `hit` is high only when the bus address, with bits below log2(size) cleared, equals the programmed base and `bus_is_io` equals 1 for an I/O window or 0 for a memory window.
- R8: Bit 0 of the command byte enables I/O decode and bit 1 enables memory decode. A command write with lane enable set updates both bits, a write with the lane enable clear is ignored, the other command bits read 0, and a window never hits while the enable for its space is clear.
- R9: A configuration or command write takes effect at the next rising clock edge, and `hit` follows the new base or enable from that edge on.
- R10: An I/O or below-4-GB window never hits an address whose bits 63:32 are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel_hi | input | 1 | Selects the upper dword for read and write |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data of the selected dword |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_be | input | 1 | Command low byte lane enable |
| cmd_wdata | input | 8 | Command low byte write data |
| cmd_rdata | output | 8 | Command low byte read-back |
| bus_addr | input | 64 | Bus address to decode |
| bus_is_io | input | 1 | 1 for an I/O space cycle, 0 for memory |
| hit | output | 1 | The window claims the bus address |

## Verification
On every cycle the assertions check that a disabled space or a mismatched space type never hits, that the bits below the window size always read as the type bits, that the upper dword of a narrow window reads zero, that the command byte never shows bits other than the two enables, and that a full low-dword write appears in the read-back one edge later. Only the directed scenarios show the exact size-probe values, the byte-lane merge, the hit and miss points at the window edges and across the 4 GB line, and the cycle in which a rewritten base or a changed enable moves the decode. The bench checks these against three instances, one of each window kind.

// File: rtl/pci_bar_decode.sv
module pci_bar_decode #(
  parameter int KIND      = 1,
  parameter bit PREFETCH  = 1'b0,
  parameter int SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel_hi,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cmd_wr,
  input  logic        cmd_be,
  input  logic [7:0]  cmd_wdata,
  output logic [7:0]  cmd_rdata,
  input  logic [63:0] bus_addr,
  input  logic        bus_is_io,
  output logic        hit
);

  localparam bit          IS_IO   = (KIND == 0);
  localparam bit          IS_64   = (KIND == 2);
  localparam logic [63:0] AMASK   = ~((64'd1 << SIZE_LOG2) - 64'd1);
  localparam logic [31:0] HW_LOW  = IS_IO ? 32'h3 : 32'hF;
  localparam logic [31:0] LO_MASK = AMASK[31:0] & ~HW_LOW;
  localparam logic [31:0] HI_MASK = IS_64 ? AMASK[63:32] : 32'h0;
  localparam logic [31:0] TYPE_BITS =
    IS_IO ? 32'h1 : {28'd0, PREFETCH, IS_64, 2'b00};

  logic [31:0] base_lo, base_hi;
  logic        io_en, mem_en;
  logic [31:0] lane_bits;

  assign lane_bits = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
      io_en   <= 1'b0;
      mem_en  <= 1'b0;
    end else begin
      if (cfg_wr && !cfg_sel_hi)
        base_lo <= (base_lo & ~(lane_bits & LO_MASK)) | (cfg_wdata & lane_bits & LO_MASK);
      if (cfg_wr && cfg_sel_hi)
        base_hi <= (base_hi & ~(lane_bits & HI_MASK)) | (cfg_wdata & lane_bits & HI_MASK);
      if (cmd_wr && cmd_be) begin
        io_en  <= cmd_wdata[0];
        mem_en <= cmd_wdata[1];
      end
    end
  end

  wire unused_cmd = ^cmd_wdata[7:2];

  assign cfg_rdata = cfg_sel_hi ? base_hi : (base_lo | TYPE_BITS);
  assign cmd_rdata = {6'd0, mem_en, io_en};

  logic space_en, kind_ok, addr_ok;
  assign space_en = IS_IO ? io_en : mem_en;
  assign kind_ok  = (bus_is_io == IS_IO);
  assign addr_ok  = ((bus_addr & AMASK) == {base_hi, base_lo});
  assign hit      = space_en && kind_ok && addr_ok;

endmodule

// File: rtl/pci_bar_decode_chk.sv
module pci_bar_decode_chk #(
  parameter int KIND      = 1,
  parameter bit PREFETCH  = 1'b0,
  parameter int SIZE_LOG2 = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_sel_hi,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [7:0]  cmd_rdata,
  input logic        bus_is_io,
  input logic        hit
);
  localparam bit          IS_IO    = (KIND == 0);
  localparam bit          IS_64    = (KIND == 2);
  localparam logic [31:0] LOW_BITS = 32'((64'd1 << SIZE_LOG2) - 64'd1);
  localparam logic [31:0] TYPE_EXP = IS_IO ? 32'h1 : {28'd0, PREFETCH, IS_64, 2'b00};

  logic my_en;
  assign my_en = IS_IO ? cmd_rdata[0] : cmd_rdata[1];

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !hit);

  p_type_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel_hi |-> ((cfg_rdata & LOW_BITS) == (TYPE_EXP & LOW_BITS)));

  p_narrow_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel_hi && !IS_64) |-> (cfg_rdata == 32'd0));

  p_space_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_is_io != IS_IO) |-> !hit);

  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !my_en |-> !hit);

  p_cmd_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[7:2] == 6'd0);

  p_write_next_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel_hi && cfg_be == 4'hF) |=>
      (cfg_sel_hi || ((cfg_rdata & ~LOW_BITS) == ($past(cfg_wdata) & ~LOW_BITS))));
endmodule

bind pci_bar_decode pci_bar_decode_chk #(
  .KIND(KIND), .PREFETCH(PREFETCH), .SIZE_LOG2(SIZE_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .cmd_rdata(cmd_rdata), .bus_is_io(bus_is_io), .hit(hit)
);

// File: tb/pci_bar_decode_tb.sv
module pci_bar_decode_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel_hi = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic        cmd_wr = 1'b0, cmd_be = 1'b0;
  logic [7:0]  cmd_wdata = '0;
  logic [63:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;

  logic [31:0] rd_m32, rd_io, rd_m64;
  logic [7:0]  cm_m32, cm_io, cm_m64;
  logic        hit_m32, hit_io, hit_m64;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bar_decode u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_m32), .cmd_wr(cmd_wr), .cmd_be(cmd_be),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cm_m32), .bus_addr(bus_addr), .bus_is_io(bus_is_io),
    .hit(hit_m32));

  pci_bar_decode #(.KIND(0), .SIZE_LOG2(5)) u_io (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_io), .cmd_wr(cmd_wr), .cmd_be(cmd_be),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cm_io), .bus_addr(bus_addr), .bus_is_io(bus_is_io),
    .hit(hit_io));

  pci_bar_decode #(.KIND(2), .PREFETCH(1'b1), .SIZE_LOG2(20)) u_m64 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_m64), .cmd_wr(cmd_wr), .cmd_be(cmd_be),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cm_m64), .bus_addr(bus_addr), .bus_is_io(bus_is_io),
    .hit(hit_m64));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic hi, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel_hi = hi; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sel_hi = 1'b0;
  endtask

  task automatic cmd_write(logic be, logic [7:0] d);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_be = be; cmd_wdata = d;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic sel(logic hi);
    cfg_sel_hi = hi; #1;
  endtask

  task automatic t_reset;
    sel(1'b0);
    check("R1 m32 lo", rd_m32, 32'h0);
    check("R2 io lo", rd_io, 32'h1);
    check("R3 m64 lo", rd_m64, 32'hC);
    sel(1'b1);
    check("R1 m64 hi", rd_m64, 32'h0);
    sel(1'b0);
    check("R1 cmd", {cm_m32, cm_io, cm_m64}, 24'h0);
    bus_addr = 64'h0; bus_is_io = 1'b0; #1;
    check("R1 hit", {hit_m32, hit_io, hit_m64}, 3'b000);
  endtask

  task automatic t_probe;
    cfg_write(1'b0, 4'hF, 32'hFFFF_FFFF);
    cfg_write(1'b1, 4'hF, 32'hFFFF_FFFF);
    sel(1'b0);
    check("R4 m32 probe", rd_m32, 32'hFFFF_F000);
    check("R4 R2 io probe", rd_io, 32'hFFFF_FFE1);
    check("R4 R3 m64 probe", rd_m64, 32'hFFF0_000C);
    sel(1'b1);
    check("R6 m64 hi probe", rd_m64, 32'hFFFF_FFFF);
    check("R6 m32 hi ignored", rd_m32, 32'h0);
    check("R6 io hi ignored", rd_io, 32'h0);
    sel(1'b0);
  endtask

  task automatic t_lanes;
    cfg_write(1'b0, 4'hF, 32'h0);
    cfg_write(1'b0, 4'b0101, 32'h1234_5678);
    sel(1'b0);
    check("R5 m32 lanes", rd_m32, 32'h0034_0000);
    check("R5 io lanes", rd_io, 32'h0034_0061);
    check("R5 m64 lanes", rd_m64, 32'h0030_000C);
  endtask

  task automatic t_decode;
    cfg_write(1'b0, 4'hF, 32'hABCD_E000);
    cfg_write(1'b1, 4'hF, 32'h0000_0001);
    bus_is_io = 1'b0; bus_addr = 64'h0000_0000_ABCD_E123; #1;
    check("R8 mem disabled", {hit_m32, hit_io, hit_m64}, 3'b000);
    cmd_write(1'b1, 8'h02);
    check("R8 cmd mem only", cm_m32, 8'h02);
    check("R7 m32 inside", {hit_m32, hit_io, hit_m64}, 3'b100);
    bus_addr = 64'h0000_0000_ABCD_EFFF; #1;
    check("R7 m32 top edge", hit_m32, 1'b1);
    bus_addr = 64'h0000_0000_ABCD_F000; #1;
    check("R7 m32 past edge", hit_m32, 1'b0);
    bus_addr = 64'h0000_0001_ABCF_FFFF; #1;
    check("R7 R10 m64 above 4G", {hit_m32, hit_io, hit_m64}, 3'b001);
    bus_addr = 64'h0000_0000_ABC0_0000; #1;
    check("R7 m64 wrong hi", hit_m64, 1'b0);
    bus_is_io = 1'b1; bus_addr = 64'h0000_0000_ABCD_E01F; #1;
    check("R8 io disabled", {hit_m32, hit_io, hit_m64}, 3'b000);
    cmd_write(1'b1, 8'hFF);
    check("R8 cmd readback", cm_io, 8'h03);
    check("R7 io inside", {hit_m32, hit_io, hit_m64}, 3'b010);
    bus_addr = 64'h0000_0000_ABCD_E020; #1;
    check("R7 io past edge", hit_io, 1'b0);
    bus_addr = 64'h0000_0001_ABCD_E01F; #1;
    check("R10 io high bits", hit_io, 1'b0);
    cmd_write(1'b0, 8'h00);
    check("R8 lane off ignored", cm_io, 8'h03);
  endtask

  task automatic t_timing;
    bus_is_io = 1'b0; bus_addr = 64'h0000_0000_ABCD_E123;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel_hi = 1'b0; cfg_be = 4'hF; cfg_wdata = 32'h5555_5000; #1;
    check("R9 old base before edge", hit_m32, 1'b1);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    check("R9 old base gone", hit_m32, 1'b0);
    bus_addr = 64'h0000_0000_5555_5ABC; #1;
    check("R9 new base", hit_m32, 1'b1);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_be = 1'b1; cmd_wdata = 8'h01; #1;
    check("R9 enable before edge", hit_m32, 1'b1);
    @(posedge clk); #1;
    cmd_wr = 1'b0;
    check("R8 R9 unmapped", hit_m32, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_probe();
    t_lanes();
    t_decode();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule